// File: doc/BRIEF.md
# I2C Target-Side Bus Decoder

This block watches the clock and data wires of an open-drain I2C bus from the target side. It turns the raw line levels into byte-level events for a register-style target that sits behind it. Each wire arrives as a pin enable plus a pin value. A wire reads high when its pin is not enabled or is driven high, which models the bus pull-up. The block combines that level with its own pull-down on the data wire, then synchronises both wires to the system clock. From the synchronised samples it finds start and stop conditions and shifts in eight bits per byte, most significant bit first.

The first byte after a start holds a 7-bit target address and a read flag. The block asks the target whether that address exists, pulls the data wire low in the acknowledge slot, and opens the transfer with a start strobe. On a write, the first data byte goes out as a pointer write and the bytes after it as data writes. On a read, the block fetches bytes from the target and shifts them onto the data wire until the controller declines a byte. An unknown address, or a write the target rejects, gets a not-acknowledge, and the block then returns to idle.

Top module: `i2c_target_frontend`

## Requirements
- R1: After reset the data pull-down (`sda_oe`) is off and no downstream strobe fires until a start condition and a full address byte have been received.
- R2: A start is the data line falling while the clock line is high. A data-line change while the clock is low is not a start. The line level is taken as high when the pin enable is 0 or the pin value is 1.
- R3: An address byte whose bits [7:1] match a present target (`tgt_present`=1) is acknowledged: the data line is held low while the ninth clock is high. `dn_start` pulses with `dn_addr` equal to that address and `dn_rd` equal to bit 0 of the byte.
- R4: An address with no target is not acknowledged, and no strobe is issued. The transfer is marked closed, and later bytes are ignored (no acknowledge, no strobe) until the next start.
- R5: In a write, the first byte after the address produces `dn_write` with `dn_ptr`=1. Later bytes produce `dn_write` with `dn_ptr`=0. Each byte is acknowledged when `tgt_ack`=1 and not acknowledged when `tgt_ack`=0.
- R6: A repeated start while a transfer is open does not issue `dn_start` again.
- R7: In a read, each byte is taken from `tgt_rdata` by a `dn_read` pulse and driven MSB first, changing while the clock is low. A controller acknowledge fetches the next byte. A controller not-acknowledge ends the transfer with no further `dn_read`.
- R8: A stop (data rising while the clock stays high) pulses `dn_stop` once if a transfer is open, and not at all otherwise. After it the transfer is closed.
- R9: An acknowledged read address issues `dn_start` and the first `dn_read` in the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_drv_en | input | 1 | Clock-wire pin enable (0 = released) |
| scl_drv_val | input | 1 | Clock-wire pin value when enabled |
| sda_drv_en | input | 1 | Data-wire pin enable from the controller side |
| sda_drv_val | input | 1 | Data-wire pin value when enabled |
| sda_oe | output | 1 | Pull the data wire low |
| dn_start | output | 1 | Transfer-open strobe |
| dn_rd | output | 1 | Read flag, valid with `dn_start` |
| dn_addr | output | 7 | Target address (address byte during decode, then the open address) |
| dn_write | output | 1 | Byte-write strobe |
| dn_ptr | output | 1 | Marks the write as the pointer byte |
| dn_wdata | output | 8 | Received byte, valid with `dn_write` |
| dn_read | output | 1 | Byte-fetch strobe |
| dn_stop | output | 1 | Transfer-close strobe |
| tgt_present | input | 1 | A target exists at `dn_addr` |
| tgt_ack | input | 1 | Target accepts the current write |
| tgt_rdata | input | 8 | Byte returned for `dn_read` |

## Verification
Two decoder functions can land on the same clock cycle: opening a transfer and fetching the first read byte. Both happen when a read address is accepted. The bench sends a fresh read address to a present target and counts the cycles in which `dn_start` and `dn_read` are both high. It expects exactly one such cycle, then checks that the byte shifted out matches the value the target model offered in that cycle. A read reached through a repeated start is used as the contrast case. There the fetch must occur without a start strobe.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    BUS_IDLE,
    BUS_RECV,
    BUS_PROC,
    BUS_SLOT,
    BUS_TX,
    BUS_MACK
  } bus_st_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA,
    PH_RD
  } phase_e;

  // level of an open-drain wire seen through a pin with a pull-up
  function automatic logic pin_level(input logic en, input logic val);
    return (!en) || val;
  endfunction

endpackage

// File: rtl/i2ct_line_sync.sv
module i2ct_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_prev, sda_prev, scl_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_prev <= scl_lvl;
      sda_prev <= sda_lvl;
    end
  end

  assign scl_lvl  = scl_pipe[STAGES-1];
  assign sda_lvl  = sda_pipe[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_prev;
  assign scl_fall = ~scl_lvl & scl_prev;
  // start needs only the clock high now; stop needs it high on both samples
  assign start_ev = scl_lvl & sda_prev & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2ct_byte_reg.sv
module i2ct_byte_reg #(
  parameter int W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       cap,
  input  logic                       cap_bit,
  input  logic                       ld,
  input  logic [W-1:0]               ld_val,
  input  logic                       sh,
  output logic [W-1:0]               q,
  output logic [$clog2(W+1)-1:0]     cnt,
  output logic                       full
);
  localparam int CW = $clog2(W+1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '1;
      cnt <= '0;
    end else if (ld) begin
      q   <= ld_val;
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (cap) begin
      q   <= {q[W-2:0], cap_bit};
      cnt <= cnt + CW'(1);
    end else if (sh) begin
      q   <= {q[W-2:0], 1'b1};
      cnt <= cnt + CW'(1);
    end
  end

  assign full = (cnt == CW'(W));

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(W));

endmodule

// File: rtl/i2c_target_frontend.sv
module i2c_target_frontend
  import i2ct_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_drv_en,
  input  logic              scl_drv_val,
  input  logic              sda_drv_en,
  input  logic              sda_drv_val,
  output logic              sda_oe,
  output logic              dn_start,
  output logic              dn_rd,
  output logic [ADDR_W-1:0] dn_addr,
  output logic              dn_write,
  output logic              dn_ptr,
  output logic [ADDR_W:0]   dn_wdata,
  output logic              dn_read,
  output logic              dn_stop,
  input  logic              tgt_present,
  input  logic              tgt_ack,
  input  logic [ADDR_W:0]   tgt_rdata
);
  localparam int BW = ADDR_W + 1;
  localparam int CW = $clog2(BW + 1);
  localparam logic [BW-1:0] ADDR_NONE = {BW{1'b1}};

  logic scl_line, sda_line;
  logic sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

  assign scl_line = pin_level(scl_drv_en, scl_drv_val);
  assign sda_line = pin_level(sda_drv_en, sda_drv_val) & ~sda_oe;

  i2ct_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  logic          clr, cap, ld, sh, full;
  logic [BW-1:0] byte_q;
  logic [CW-1:0] cnt;

  i2ct_byte_reg #(.W(BW)) u_byte (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cap(cap), .cap_bit(sda_lvl),
    .ld(ld), .ld_val(tgt_rdata), .sh(sh), .q(byte_q), .cnt(cnt), .full(full)
  );

  bus_st_e       st_q, st_d;
  phase_e        ph_q, ph_d;
  logic [BW-1:0] addr_q, addr_d;
  logic [1:0]    slot_q, slot_d;
  logic          nack_q, nack_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BUS_IDLE;
      ph_q   <= PH_ADDR;
      addr_q <= ADDR_NONE;
      slot_q <= 2'd0;
      nack_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      addr_q <= addr_d;
      slot_q <= slot_d;
      nack_q <= nack_d;
    end
  end

  always_comb begin
    st_d     = st_q;
    ph_d     = ph_q;
    addr_d   = addr_q;
    slot_d   = slot_q;
    nack_d   = nack_q;
    clr      = 1'b0;
    cap      = 1'b0;
    ld       = 1'b0;
    sh       = 1'b0;
    dn_start = 1'b0;
    dn_write = 1'b0;
    dn_read  = 1'b0;
    dn_stop  = 1'b0;
    if (stop_ev) begin
      dn_stop = (addr_q != ADDR_NONE);
      addr_d  = ADDR_NONE;
      st_d    = BUS_IDLE;
      ph_d    = PH_ADDR;
    end else if (start_ev) begin
      st_d = BUS_RECV;
      ph_d = PH_ADDR;
      clr  = 1'b1;
    end else begin
      case (st_q)
        BUS_RECV: begin
          if (full) st_d = BUS_PROC;
          else if (scl_rise) cap = 1'b1;
        end
        BUS_PROC: begin
          st_d   = BUS_SLOT;
          slot_d = 2'd0;
          nack_d = 1'b0;
          case (ph_q)
            PH_ADDR: begin
              if (!tgt_present) begin
                addr_d = ADDR_NONE;
                nack_d = 1'b1;
              end else begin
                dn_start = (addr_q == ADDR_NONE);
                addr_d   = {1'b0, byte_q[BW-1:1]};
                if (byte_q[0]) begin
                  dn_read = 1'b1;
                  ld      = 1'b1;
                  ph_d    = PH_RD;
                end else begin
                  ph_d = PH_PTR;
                end
              end
            end
            PH_PTR, PH_DATA: begin
              dn_write = 1'b1;
              if (tgt_ack) ph_d = PH_DATA;
              else nack_d = 1'b1;
            end
            default: nack_d = 1'b1;
          endcase
        end
        BUS_SLOT: begin
          case (slot_q)
            2'd0: if (scl_fall) slot_d = 2'd1;
            2'd1: if (scl_rise) slot_d = 2'd2;
            default: begin
              if (scl_fall) begin
                if (nack_q) begin
                  st_d = BUS_IDLE;
                  ph_d = PH_ADDR;
                end else if (ph_q == PH_RD) begin
                  st_d = BUS_TX;
                end else begin
                  st_d = BUS_RECV;
                  clr  = 1'b1;
                end
              end
            end
          endcase
        end
        BUS_TX: begin
          if (scl_fall) begin
            sh = 1'b1;
            if (cnt == CW'(BW - 1)) begin
              st_d   = BUS_MACK;
              slot_d = 2'd0;
            end
          end
        end
        BUS_MACK: begin
          if (slot_q == 2'd0) begin
            if (scl_rise) begin
              if (sda_lvl) begin
                st_d = BUS_IDLE;
                ph_d = PH_ADDR;
              end else begin
                dn_read = 1'b1;
                ld      = 1'b1;
                slot_d  = 2'd1;
              end
            end
          end else if (scl_fall) begin
            st_d = BUS_TX;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe   = ((st_q == BUS_SLOT) && (slot_q != 2'd0) && !nack_q) ||
                    ((st_q == BUS_TX) && !byte_q[BW-1]);
  assign dn_rd    = byte_q[0];
  assign dn_addr  = ((st_q == BUS_PROC) && (ph_q == PH_ADDR)) ? byte_q[BW-1:1]
                                                               : addr_q[ADDR_W-1:0];
  assign dn_ptr   = (ph_q == PH_PTR);
  assign dn_wdata = byte_q;

  // R3
  oe_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st_q == BUS_SLOT || st_q == BUS_TX));

  // R4
  miss_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BUS_PROC && ph_q == PH_ADDR && !tgt_present) |=>
      (addr_q == ADDR_NONE && nack_q && !sda_oe));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dn_start | dn_read, dn_write, dn_stop}));

  // R6
  start_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_start |=> (addr_q != ADDR_NONE));

  // R8
  stop_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_stop |=> (addr_q == ADDR_NONE && st_q == BUS_IDLE));

  // R9
  read_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_start && dn_rd) |-> dn_read);

endmodule

// File: tb/sim_i2c_target_frontend.sv
module sim_i2c_target_frontend;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl_en = 1'b0, scl_val = 1'b0, sda_en = 1'b0, sda_val = 1'b0;
  logic sda_oe, dn_start, dn_rd, dn_write, dn_ptr, dn_read, dn_stop;
  logic [6:0] dn_addr;
  logic [7:0] dn_wdata, tgt_rdata, rd_idx;
  logic tgt_present, tgt_ack;

  i2c_target_frontend u0 (
    .clk(clk), .rst_n(rst_n),
    .scl_drv_en(scl_en), .scl_drv_val(scl_val),
    .sda_drv_en(sda_en), .sda_drv_val(sda_val),
    .sda_oe(sda_oe), .dn_start(dn_start), .dn_rd(dn_rd), .dn_addr(dn_addr),
    .dn_write(dn_write), .dn_ptr(dn_ptr), .dn_wdata(dn_wdata),
    .dn_read(dn_read), .dn_stop(dn_stop),
    .tgt_present(tgt_present), .tgt_ack(tgt_ack), .tgt_rdata(tgt_rdata)
  );

  // target model: one device at 0x50, refuses the byte 0xEE
  assign tgt_present = (dn_addr == 7'h50);
  assign tgt_ack     = (dn_wdata != 8'hEE);
  assign tgt_rdata   = 8'hA0 + rd_idx;
  always @(posedge clk) begin
    if (!rst_n) rd_idx <= 8'd0;
    else if (dn_read) rd_idx <= rd_idx + 8'd1;
  end

  wire bus_sda = (!sda_en || sda_val) && !sda_oe;

  int n_start = 0, n_write = 0, n_read = 0, n_stop = 0, n_pair = 0, n_oe = 0;
  logic [7:0] last_wdata;
  logic last_ptr, last_rd;
  logic [6:0] last_saddr;
  always @(negedge clk) begin
    if (rst_n) begin
      if (dn_start) begin n_start++; last_rd = dn_rd; last_saddr = dn_addr; end
      if (dn_start && dn_read) n_pair++;
      if (dn_write) begin n_write++; last_wdata = dn_wdata; last_ptr = dn_ptr; end
      if (dn_read) n_read++;
      if (dn_stop) n_stop++;
      if (sda_oe) n_oe++;
    end
  end

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic scl_hi(); scl_en = 1'b1; scl_val = 1'b1; endtask
  task automatic scl_lo(); scl_en = 1'b1; scl_val = 1'b0; endtask

  task automatic m_start();
    sda_en = 1'b0; tick(H);
    scl_hi(); tick(H);
    sda_en = 1'b1; sda_val = 1'b0; tick(H);
    scl_lo(); tick(2);
  endtask

  task automatic m_stop();
    sda_en = 1'b1; sda_val = 1'b0; tick(H);
    scl_hi(); tick(H);
    sda_en = 1'b0; tick(H);
  endtask

  task automatic m_bit(input logic b);
    sda_en = 1'b1; sda_val = b; tick(H);
    scl_hi(); tick(H);
    scl_lo(); tick(2);
  endtask

  task automatic m_wbyte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) m_bit(b[i]);
    sda_en = 1'b0; tick(H);
    scl_hi(); tick(H/2);
    acked = !bus_sda;
    tick(H/2);
    scl_lo(); tick(2);
  endtask

  task automatic m_rbyte(input logic give_ack, output logic [7:0] d);
    sda_en = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      scl_hi(); tick(H/2);
      d[i] = bus_sda;
      tick(H/2);
      scl_lo(); tick(2);
    end
    sda_en = give_ack; sda_val = 1'b0; tick(H);
    scl_hi(); tick(H);
    scl_lo(); tick(2);
    sda_en = 1'b0;
  endtask

  // {address, data byte, address acked, data acked}
  localparam logic [16:0] VEC [4] = '{
    {7'h50, 8'h3C, 1'b1, 1'b1},
    {7'h51, 8'h3C, 1'b0, 1'b0},
    {7'h50, 8'hEE, 1'b1, 1'b0},
    {7'h50, 8'h01, 1'b1, 1'b1}
  };

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic ack;
    logic [16:0] v;
    logic [7:0] d;
    int s0, w0, r0, p0, o0;
    logic [7:0] i0;
    tick(5);
    rst_n = 1'b1;
    scl_hi();
    tick(4);

    // R1 reset state
    chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);
    chk(n_start + n_write + n_read + n_stop == 0, "R1 strobes after reset",
        n_start + n_write + n_read + n_stop, 0);

    // R2 data change with clock low is not a start
    scl_lo(); tick(H);
    sda_en = 1'b1; sda_val = 1'b0; tick(H);
    sda_en = 1'b0; tick(H);
    m_wbyte(8'hA0, ack);
    chk(ack == 1'b0 && n_start == 0, "R2 no false start", ack, 0);
    m_stop();

    // table-driven single-byte writes
    for (int i = 0; i < 4; i++) begin
      v = VEC[i];
      s0 = n_start; w0 = n_write; p0 = n_stop;
      m_start();
      m_wbyte({v[16:10], 1'b0}, ack);
      chk(ack == v[1], "R3/R4 address ack", ack, v[1]);
      chk(n_start - s0 == int'(v[1]), "R3 start strobe count", n_start - s0, v[1]);
      if (v[1]) begin
        chk(last_saddr == v[16:10] && last_rd == 1'b0, "R3 start address/flag",
            last_saddr, v[16:10]);
        m_wbyte(v[9:2], ack);
        chk(ack == v[0], "R5 pointer byte ack", ack, v[0]);
        chk(last_wdata == v[9:2] && last_ptr == 1'b1, "R5 pointer write", last_wdata, v[9:2]);
      end else begin
        o0 = n_oe;
        m_wbyte(8'hA5, ack);
        chk(ack == 1'b0 && n_write == w0 && n_oe == o0, "R4 bytes ignored after miss",
            n_write - w0, 0);
      end
      m_stop();
      chk(n_stop - p0 == int'(v[1]), "R8 stop forwarding", n_stop - p0, v[1]);
    end

    // R5 pointer then data
    w0 = n_write;
    m_start();
    m_wbyte(8'hA0, ack);
    m_wbyte(8'h10, ack);
    m_wbyte(8'h77, ack);
    chk(ack && last_ptr == 1'b0 && last_wdata == 8'h77, "R5 data write", last_wdata, 8'h77);
    chk(n_write - w0 == 2, "R5 write count", n_write - w0, 2);
    m_stop();

    // R6/R7 repeated start read
    s0 = n_start; r0 = n_read; p0 = n_stop; i0 = rd_idx;
    m_start();
    m_wbyte(8'hA0, ack);
    m_wbyte(8'h02, ack);
    m_start();
    m_wbyte(8'hA1, ack);
    chk(ack == 1'b1, "R7 read address ack", ack, 1);
    chk(n_start - s0 == 1, "R6 single start across repeat", n_start - s0, 1);
    m_rbyte(1'b1, d);
    chk(d == 8'hA0 + i0, "R7 first read byte", d, 8'hA0 + i0);
    m_rbyte(1'b0, d);
    chk(d == 8'hA1 + i0, "R7 second read byte", d, 8'hA1 + i0);
    tick(H);
    chk(n_read - r0 == 2, "R7 no fetch after nack", n_read - r0, 2);
    m_stop();
    chk(n_stop - p0 == 1, "R8 stop after read", n_stop - p0, 1);

    // R9 start and fetch together on fresh read
    s0 = n_pair; i0 = rd_idx;
    m_start();
    m_wbyte(8'hA1, ack);
    chk(n_pair - s0 == 1 && last_rd == 1'b1, "R9 start with read", n_pair - s0, 1);
    m_rbyte(1'b0, d);
    chk(d == 8'hA0 + i0, "R9 fetched byte", d, 8'hA0 + i0);
    m_stop();

    // R8 stop with nothing open
    p0 = n_stop;
    m_start();
    m_stop();
    chk(n_stop == p0, "R8 no stop when closed", n_stop - p0, 0);

    finish_run();
  end
endmodule